// File: doc/BRIEF.md
# Three-Level Switching Sequence Monitor

This block observes the leg states that a three-level modulator applies to a three-phase bridge. Each leg is positive, mid or negative. The block receives a new state through a valid pulse and a strobe that marks each sampling-period boundary. It checks the stream against the rules that a synchronized low-carrier-ratio sequence must obey, and latches one sticky flag for each kind of violation.

The same stream feeds a common-mode metric. The block forms the signed sum of the three leg levels, which is also the common-mode voltage in sixths of the DC link. It also forms the magnitude of that sum and keeps the peak magnitude seen since the last clear. A sequence built from minimum-magnitude redundant states keeps the peak at one sixth of the link. A sequence that parks on all-positive or all-negative zero states reaches three sixths.

The monitor only watches the stream. It sits beside the modulator, and firmware or a fault path reads its flags and peak.

Top module: `tlm_seq_monitor`

## Requirements
- R1: A leg code of 2'b01 means positive (+1), 2'b00 means mid (0) and 2'b11 means negative (-1); leg A is leg_code[1:0], B is [3:2], C is [5:4]. A valid sample with any leg coded 2'b10 sets err_flags[0] and is otherwise discarded: the metric outputs, the per-leg counts and the remembered previous state are left unchanged.
- R2: One cycle after an accepted sample, cm_sixths holds the signed sum of the three leg levels and k_mag holds its magnitude.
- R3: peak_k holds the largest k_mag of any accepted sample since reset or the last clear, and lowers only on a clear.
- R4: An accepted sample in which some leg steps directly between positive and negative sets err_flags[1], whether or not a period strobe comes in the same cycle.
- R5: An accepted sample that changes more than one leg relative to the previous accepted sample sets err_flags[2].
- R6: A leg that switches a third time within one sampling period sets err_flags[3]. leg_sw_cnt holds each leg's switch count for the period, in CNT_W-bit fields with leg A lowest, and the count saturates at three.
- R7: When all three legs have switched within one sampling period, err_flags[4] is set.
- R8: A period_strobe zeroes the per-leg counts and the set of legs switched. A transition accepted in the same cycle counts toward the new period.
- R9: The flags are sticky. err_clear zeroes all flags and peak_k. It has priority over any violation and any sample in the same cycle, although that sample still updates the state, the counts and cm_sixths and k_mag.
- R10: The first accepted sample after reset has no predecessor and is checked for no transition rule.
- R11: After reset, all flags, counts, cm_sixths, k_mag and peak_k read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new leg state is present |
| leg_code | input | 6 | Leg codes {C, B, A}, 2 bits each |
| period_strobe | input | 1 | Start of a sampling period |
| err_clear | input | 1 | Clears the flags and the peak |
| err_flags | output | 5 | Sticky flags: code, pos/neg step, multi-leg step, leg overuse, three legs in period |
| cm_sixths | output | 3 | Signed common-mode level in units of Vdc/6 |
| k_mag | output | 2 | Magnitude of the level sum |
| peak_k | output | 2 | Peak magnitude since reset or clear |
| leg_sw_cnt | output | 6 | Per-leg switch counts in the current period |

## Verification
The bench sweeps every ordered pair of the 27 legal states, each pair in a period of its own. This catches a wrong sum or magnitude, a missed positive/negative step, or a multi-leg or three-leg rule that tests the wrong number. Directed sequences cover the following cases:
- A leg toggled a third time within one period, which a design counting off by one would either miss or flag too early.
- A strobe placed between two toggles, which a design that does not clear its counters would wrongly flag.
- A positive/negative step that coincides with a strobe.
- A malformed code, which a careless design would fold into the sum.
- A clear that arrives together with a violation, which a design giving the set priority would leave latched.
- The first sample after reset, which a design comparing against the reset value would flag.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam logic [1:0] LVL_POS = 2'b01;
  localparam logic [1:0] LVL_MID = 2'b00;
  localparam logic [1:0] LVL_NEG = 2'b11;
  localparam logic [1:0] LVL_BAD = 2'b10;

  localparam int FLG_CODE   = 0;
  localparam int FLG_PNSTEP = 1;
  localparam int FLG_MULTI  = 2;
  localparam int FLG_LEGSW  = 3;
  localparam int FLG_SPREAD = 4;
  localparam int NFLAGS     = 5;

  function automatic logic lvl_legal(input logic [1:0] code);
    return code != LVL_BAD;
  endfunction

  function automatic logic lvl_opposite(input logic [1:0] a, input logic [1:0] b);
    return ((a == LVL_POS) && (b == LVL_NEG)) || ((a == LVL_NEG) && (b == LVL_POS));
  endfunction
endpackage

// File: rtl/tlm_leg_track.sv
module tlm_leg_track #(
  parameter int MAX_SW = 2,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             have_prev,
  input  logic             strobe,
  input  logic [1:0]       code,
  output logic             chg,
  output logic             pn,
  output logic             over,
  output logic             touch_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  import tlm_pkg::*;

  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic [1:0]       prev_q;
  logic             touch_q;
  logic [CNT_W-1:0] base_cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    chg       = take && have_prev && (code != prev_q);
    pn        = chg && lvl_opposite(prev_q, code);
    base_cnt  = strobe ? '0 : cnt_q;
    touch_nxt = (strobe ? 1'b0 : touch_q) | chg;
    over      = chg && (base_cnt >= CNT_W'(MAX_SW));
    if (chg && (base_cnt != CNT_W'(CNT_TOP)))
      cnt_nxt = base_cnt + CNT_W'(1);
    else
      cnt_nxt = base_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= LVL_MID;
      touch_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (take) prev_q <= code;
      touch_q <= touch_nxt;
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tlm_cm_metric.sv
module tlm_cm_metric #(
  parameter int LEGS  = 3,
  parameter int SUM_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic                    clr,
  input  logic [2*LEGS-1:0]       codes,
  output logic signed [SUM_W-1:0] sum_q,
  output logic [SUM_W-2:0]        k_q,
  output logic [SUM_W-2:0]        peak_q
);
  logic signed [SUM_W-1:0] sum_c;
  logic signed [SUM_W-1:0] abs_c;
  logic [SUM_W-2:0]        k_c;

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < LEGS; i++)
      sum_c = sum_c + SUM_W'($signed(codes[2*i +: 2]));
    abs_c = sum_c[SUM_W-1] ? -sum_c : sum_c;
    k_c   = (SUM_W-1)'(abs_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      k_q    <= '0;
      peak_q <= '0;
    end else begin
      if (take) begin
        sum_q <= sum_c;
        k_q   <= k_c;
      end
      if (clr)
        peak_q <= '0;
      else if (take && (k_c > peak_q))
        peak_q <= k_c;
    end
  end
endmodule

// File: rtl/tlm_flag_bank.sv
module tlm_flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [NF-1:0] set,
  output logic [NF-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) flags_q <= '0;
    else            flags_q <= flags_q | set;
  end
endmodule

// File: rtl/tlm_seq_monitor.sv
module tlm_seq_monitor #(
  parameter int LEGS                = 3,
  parameter int MAX_SW_PER_LEG      = 2,
  parameter int MAX_LEGS_PER_PERIOD = 2,
  parameter int MAX_LEGS_PER_STEP   = 1,
  localparam int CNT_W = $clog2(MAX_SW_PER_LEG + 2),
  localparam int SUM_W = $clog2(LEGS + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2*LEGS-1:0]       leg_code,
  input  logic                    period_strobe,
  input  logic                    err_clear,
  output logic [4:0]              err_flags,
  output logic signed [SUM_W-1:0] cm_sixths,
  output logic [SUM_W-2:0]        k_mag,
  output logic [SUM_W-2:0]        peak_k,
  output logic [LEGS*CNT_W-1:0]   leg_sw_cnt
);
  import tlm_pkg::*;

  logic            all_legal;
  logic            take;
  logic            have_prev_q;
  logic [LEGS-1:0] chg_v, pn_v, over_v, touch_v;
  int              n_chg, n_touch;
  logic [NFLAGS-1:0] set_v;

  always_comb begin
    all_legal = 1'b1;
    for (int i = 0; i < LEGS; i++)
      if (!lvl_legal(leg_code[2*i +: 2])) all_legal = 1'b0;
  end

  assign take = in_valid && all_legal;

  always_ff @(posedge clk) begin
    if (rst)       have_prev_q <= 1'b0;
    else if (take) have_prev_q <= 1'b1;
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    tlm_leg_track #(.MAX_SW(MAX_SW_PER_LEG), .CNT_W(CNT_W)) u_leg (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .have_prev (have_prev_q),
      .strobe    (period_strobe),
      .code      (leg_code[2*g +: 2]),
      .chg       (chg_v[g]),
      .pn        (pn_v[g]),
      .over      (over_v[g]),
      .touch_nxt (touch_v[g]),
      .cnt_q     (leg_sw_cnt[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    n_chg   = 0;
    n_touch = 0;
    for (int i = 0; i < LEGS; i++) begin
      n_chg   = n_chg + int'(chg_v[i]);
      n_touch = n_touch + int'(touch_v[i]);
    end
    set_v             = '0;
    set_v[FLG_CODE]   = in_valid && !all_legal;
    set_v[FLG_PNSTEP] = |pn_v;
    set_v[FLG_MULTI]  = n_chg > MAX_LEGS_PER_STEP;
    set_v[FLG_LEGSW]  = |over_v;
    set_v[FLG_SPREAD] = n_touch > MAX_LEGS_PER_PERIOD;
  end

  tlm_flag_bank #(.NF(NFLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (err_clear),
    .set     (set_v),
    .flags_q (err_flags)
  );

  tlm_cm_metric #(.LEGS(LEGS), .SUM_W(SUM_W)) u_cm (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .clr    (err_clear),
    .codes  (leg_code),
    .sum_q  (cm_sixths),
    .k_q    (k_mag),
    .peak_q (peak_k)
  );
endmodule

// File: rtl/tlm_seq_monitor_chk.sv
module tlm_seq_monitor_chk #(
  parameter int LEGS  = 3,
  parameter int CNT_W = 2,
  parameter int SUM_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [2*LEGS-1:0]       leg_code,
  input logic                    period_strobe,
  input logic                    err_clear,
  input logic [4:0]              err_flags,
  input logic signed [SUM_W-1:0] cm_sixths,
  input logic [SUM_W-2:0]        k_mag,
  input logic [SUM_W-2:0]        peak_k,
  input logic [LEGS*CNT_W-1:0]   leg_sw_cnt
);
  logic legal_c;
  logic acc_q;

  always_comb begin
    legal_c = 1'b1;
    for (int i = 0; i < LEGS; i++)
      if (leg_code[2*i +: 2] == 2'b10) legal_c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= 1'b0;
    else     acc_q <= in_valid && legal_c && !err_clear;
  end

  assert_reset_zero_R11: assert property (@(posedge clk)
    rst |=> (err_flags == '0 && peak_k == '0 && leg_sw_cnt == '0 && k_mag == '0));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> (err_flags == '0 && peak_k == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !err_clear |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_peak_covers_R3: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> (peak_k >= k_mag));

  assert_cm_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cm_sixths <= SUM_W'(LEGS)) && (cm_sixths >= -SUM_W'(LEGS)));

  assert_strobe_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (period_strobe && !in_valid) |=> (leg_sw_cnt == '0));

  assert_bad_code_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal_c && !err_clear) |=> (err_flags[0] && $stable(cm_sixths) && $stable(leg_sw_cnt)));
endmodule

bind tlm_seq_monitor tlm_seq_monitor_chk #(.LEGS(LEGS), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .leg_code      (leg_code),
  .period_strobe (period_strobe),
  .err_clear     (err_clear),
  .err_flags     (err_flags),
  .cm_sixths     (cm_sixths),
  .k_mag         (k_mag),
  .peak_k        (peak_k),
  .leg_sw_cnt    (leg_sw_cnt)
);

// File: tb/tlm_seq_monitor_bench.sv
module tlm_seq_monitor_bench;
  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [5:0]        leg_code;
  logic              period_strobe;
  logic              err_clear;
  logic [4:0]        err_flags;
  logic signed [2:0] cm_sixths;
  logic [1:0]        k_mag;
  logic [1:0]        peak_k;
  logic [5:0]        leg_sw_cnt;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  tlm_seq_monitor u_tlm_seq_monitor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .leg_code(leg_code),
    .period_strobe(period_strobe), .err_clear(err_clear), .err_flags(err_flags),
    .cm_sixths(cm_sixths), .k_mag(k_mag), .peak_k(peak_k), .leg_sw_cnt(leg_sw_cnt)
  );

  function automatic logic [1:0] enc(input int l);
    return (l > 0) ? 2'b01 : (l < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic logic [5:0] st(input int a, input int b, input int c);
    return {enc(c), enc(b), enc(a)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [5:0] code, input bit s, input bit c);
    in_valid = v; leg_code = code; period_strobe = s; err_clear = c;
    @(negedge clk);
    in_valid = 0; period_strobe = 0; err_clear = 0;
  endtask

  task automatic fresh(input logic [5:0] code);
    step(1, code, 1, 1);
    step(0, code, 1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; leg_code = 0; period_strobe = 0; err_clear = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 flags", int'(err_flags), 0);
    check("R11 cm", int'(cm_sixths), 0);
    check("R11 peak", int'(peak_k), 0);
    check("R11 cnt", int'(leg_sw_cnt), 0);

    // R10 first sample: all-negative, no predecessor
    step(1, st(-1,-1,-1), 0, 0);
    check("R10 flags", int'(err_flags), 0);
    check("R2 cm", int'(cm_sixths), -3);
    check("R2 k", int'(k_mag), 3);
    check("R3 peak", int'(peak_k), 3);
    check("R6 cnt first", int'(leg_sw_cnt), 0);
    step(0, 0, 0, 1);
    check("R9 clear peak", int'(peak_k), 0);

    // exhaustive ordered pairs
    for (int i = 0; i < 27; i++) begin
      for (int j = 0; j < 27; j++) begin
        int a1, b1, c1, a2, b2, c2, nch, s, expf, expc;
        bit pn;
        a1 = i % 3 - 1; b1 = (i / 3) % 3 - 1; c1 = i / 9 - 1;
        a2 = j % 3 - 1; b2 = (j / 3) % 3 - 1; c2 = j / 9 - 1;
        fresh(st(a1, b1, c1));
        step(1, st(a2, b2, c2), 0, 0);
        nch = int'(a1 != a2) + int'(b1 != b2) + int'(c1 != c2);
        pn = (a1 * a2 < 0) || (b1 * b2 < 0) || (c1 * c2 < 0);
        s = a2 + b2 + c2;
        expf = (pn ? 2 : 0) | ((nch > 1) ? 4 : 0) | ((nch > 2) ? 16 : 0);
        expc = int'(a1 != a2) | (int'(b1 != b2) << 2) | (int'(c1 != c2) << 4);
        check("R4 R5 R7 pair flags", int'(err_flags), expf);
        check("R2 pair cm", int'(cm_sixths), s);
        check("R3 pair peak", int'(peak_k), (s < 0) ? -s : s);
        check("R8 pair cnt", int'(leg_sw_cnt), expc);
      end
    end

    // R6 third toggle of leg A in one period
    fresh(st(0,0,0));
    step(1, st(1,0,0), 0, 0);
    step(1, st(0,0,0), 0, 0);
    check("R6 two toggles ok", int'(err_flags), 0);
    check("R6 count two", int'(leg_sw_cnt), 2);
    step(1, st(1,0,0), 0, 0);
    check("R6 third toggle", int'(err_flags), 8);
    check("R6 count three", int'(leg_sw_cnt), 3);
    step(1, st(0,0,0), 0, 0);
    check("R6 saturate", int'(leg_sw_cnt), 3);

    // R8 strobe between toggles
    fresh(st(0,0,0));
    step(1, st(1,0,0), 0, 0);
    step(1, st(0,0,0), 1, 0);
    check("R8 new period count", int'(leg_sw_cnt), 1);
    step(1, st(1,0,0), 0, 0);
    step(0, 0, 1, 0);
    check("R8 strobe zeroes", int'(leg_sw_cnt), 0);
    check("R8 no overuse", int'(err_flags), 0);

    // R7 all three legs in one period
    fresh(st(0,0,0));
    step(1, st(1,0,0), 0, 0);
    step(1, st(1,0,-1), 0, 0);
    check("R7 two legs ok", int'(err_flags), 0);
    check("R7 cnt", int'(leg_sw_cnt), 6'b01_00_01);
    step(1, st(1,1,-1), 0, 0);
    check("R7 third leg", int'(err_flags), 16);

    // R1 malformed code
    fresh(st(0,0,0));
    step(1, 6'b00_00_10, 0, 0);
    check("R1 flag", int'(err_flags), 1);
    check("R1 cm held", int'(cm_sixths), 0);
    check("R1 cnt held", int'(leg_sw_cnt), 0);
    step(1, st(1,0,0), 0, 0);
    check("R1 prev kept", int'(err_flags), 1);
    check("R1 cm next", int'(cm_sixths), 1);

    // R3 peak hold
    fresh(st(0,0,0));
    step(1, st(1,0,0), 0, 0);
    check("R3 peak one", int'(peak_k), 1);
    step(1, st(1,1,0), 0, 0);
    step(1, st(1,1,1), 0, 0);
    step(1, st(1,1,0), 0, 0);
    check("R3 k now", int'(k_mag), 2);
    check("R3 peak held", int'(peak_k), 3);

    // R9 sticky and clear priority
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    check("R9 sticky", int'(err_flags), 16);
    fresh(st(0,0,0));
    step(1, st(1,0,-1), 0, 1);
    check("R9 clear beats set", int'(err_flags), 0);
    check("R9 clear cm updates", int'(cm_sixths), 0);
    check("R9 clear peak", int'(peak_k), 0);

    // R4 positive/negative step on a period boundary
    fresh(st(1,0,0));
    step(1, st(-1,0,0), 1, 0);
    check("R4 boundary step", int'(err_flags), 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule